// File: doc/BRIEF.md
# Multithreaded Translation Request Slot Manager

This block sits between the stages of a multithreaded in-order pipeline and an address translation lookup port. A stage presents one translation command per cycle, tagged with its thread, its own stage index and the instruction's sequence number. The command is an instruction fetch, a data read or a data write. The block checks that the command is legal and that the thread may issue, then picks a free request slot. It forwards the virtual address to the lookup port along with the permission the command needs. The lookup port answers in the same cycle.

A clean lookup completes at once: the slot is released and the physical address is returned. A fault on a real access is handled differently. The block keeps the slot occupied for a fixed wake-up delay, blocks the faulting thread, stalls the issuing stage and emits a trap with the fault code. If the access is a data prefetch, the fault is discarded and the request completes as a clean one. When the wake-up delay expires, the slot is released, and with it the thread's block and the stage's stall.

A squash names a thread and a sequence number. It cancels every younger slot of that thread at once, which drops its pending wake-up.

Top module: `xlat_slot_mgr`

## Requirements
- R1: After reset, `rsp_valid`, `trap_valid`, every bit of `blocked_o`, every bit of `stall_o` and every bit of `squash_mask` are 0.
- R2: An accepted request takes the free slot with the lowest index, and that index is returned in `rsp_slot` on the cycle after the request.
- R3: `req_cmd` is decoded as follows: 0 is fetch and is looked up with `lk_perm`=0 (execute), 1 is data read with `lk_perm`=1, 2 is data write with `lk_perm`=2. Code 3 is illegal; it raises no lookup (`lk_valid`=0) and gives `rsp_status`=3.
- R4: A lookup without a fault gives `rsp_status`=0 (done) one cycle later, with `rsp_paddr` equal to the port's physical address. The slot stays free.
- R5: A lookup fault on a non-prefetch access gives `rsp_status`=1 (fault) one cycle later. In the same cycle `trap_valid`=1, `trap_tid` is the requesting thread, `trap_code` is the port's fault code, `blocked_o[tid]`=1 and `stall_o[stage]`=1.
- R6: A fault on a data read or data write with `req_prefetch`=1 is dropped: status done, physical address returned, no trap, no block and no stall. For a fetch, `req_prefetch` has no effect.
- R7: A legal request from a thread whose `blocked_o` bit is set gets `rsp_status`=2 (reject) and no lookup. Other threads are still served.
- R8: A legal request from an unblocked thread gets `rsp_status`=2 while every slot is occupied.
- R9: A faulted slot is released exactly `WAKE_DLY` cycles after the cycle in which its response appears. At that point its thread's block bit and its stage's stall bit drop, unless another held slot still needs them.
- R10: A squash frees every occupied slot of `sq_tid` whose sequence number, compared unsigned, is greater than `sq_seq`. The following cycle, `squash_mask` has a 1 for each such slot, and the block and stall bits those slots held are released. Their wake-up is cancelled.
- R11: A squash leaves untouched the slots of other threads and the slots whose sequence number is equal to or smaller than `sq_seq`. Such slots give 0 in `squash_mask` and keep their block and stall bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation command present |
| req_tid | input | TID_W | Requesting thread |
| req_stage | input | STG_W | Issuing pipeline stage |
| req_seq | input | SEQ_W | Instruction sequence number |
| req_cmd | input | 2 | Command code (see R3) |
| req_prefetch | input | 1 | Instruction is a data prefetch |
| req_vaddr | input | VA_W | Virtual address |
| lk_valid | output | 1 | Lookup issued this cycle |
| lk_vaddr | output | VA_W | Address to translate |
| lk_perm | output | 2 | Permission checked: 0 execute, 1 read, 2 write |
| lk_fault | input | 1 | Lookup faulted (same cycle) |
| lk_fault_code | input | FC_W | Fault cause |
| lk_paddr | input | PA_W | Translated address |
| sq_valid | input | 1 | Squash present |
| sq_tid | input | TID_W | Thread being squashed |
| sq_seq | input | SEQ_W | Youngest surviving sequence number |
| rsp_valid | output | 1 | Response to last cycle's request |
| rsp_status | output | 2 | 0 done, 1 fault, 2 reject, 3 illegal |
| rsp_slot | output | SLOT_W | Slot used |
| rsp_paddr | output | PA_W | Physical address on done |
| trap_valid | output | 1 | Trap raised |
| trap_tid | output | TID_W | Trapping thread |
| trap_code | output | FC_W | Fault cause of the trap |
| stall_o | output | NUM_STAGES | Per-stage stall |
| blocked_o | output | NUM_THREADS | Per-thread block |
| squash_mask | output | NUM_SLOTS | Slots freed by last cycle's squash |

## Verification
The bench builds the block with two slots, four threads, four stages and a wake-up delay of three cycles. With fewer slots than threads, the bench can fill every slot with faulted requests from unblocked threads, which exercises the full-pool reject. The three-cycle wake-up leaves room to issue a second fault and then a squash while the first slot is still held, so the cancellation of a pending wake-up and the selective release of one thread among two held ones can both be observed.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        CMD_FETCH  = 2'd0,
        CMD_DREAD  = 2'd1,
        CMD_DWRITE = 2'd2,
        CMD_BAD    = 2'd3
    } xcmd_e;

    typedef enum logic [1:0] {
        PERM_EXEC  = 2'd0,
        PERM_READ  = 2'd1,
        PERM_WRITE = 2'd2
    } perm_e;

    typedef enum logic [1:0] {
        ST_DONE    = 2'd0,
        ST_FAULT   = 2'd1,
        ST_REJECT  = 2'd2,
        ST_ILLEGAL = 2'd3
    } rsp_st_e;

    function automatic logic cmd_legal(input logic [1:0] c);
        return c != CMD_BAD;
    endfunction

    function automatic logic cmd_is_data(input logic [1:0] c);
        return (c == CMD_DREAD) || (c == CMD_DWRITE);
    endfunction

    function automatic logic [1:0] cmd_perm(input logic [1:0] c);
        case (c)
            CMD_DREAD:  return PERM_READ;
            CMD_DWRITE: return PERM_WRITE;
            default:    return PERM_EXEC;
        endcase
    endfunction

endpackage

// File: rtl/xlat_free_pick.sv
module xlat_free_pick #(
    parameter int N      = 4,
    parameter int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     busy,
    output logic             any_free,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx      = '0;
        any_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                idx      = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xlat_slot_entry.sv
module xlat_slot_entry #(
    parameter int TID_W    = 2,
    parameter int STG_W    = 2,
    parameter int SEQ_W    = 8,
    parameter int WAKE_DLY = 1,
    localparam int TMR_W   = $clog2(WAKE_DLY + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TID_W-1:0] ld_tid,
    input  logic [STG_W-1:0] ld_stage,
    input  logic [SEQ_W-1:0] ld_seq,
    input  logic             sq_valid,
    input  logic [TID_W-1:0] sq_tid,
    input  logic [SEQ_W-1:0] sq_seq,
    output logic             busy,
    output logic [TID_W-1:0] tid_o,
    output logic [STG_W-1:0] stage_o,
    output logic             kill_o
);
    logic [SEQ_W-1:0] seq_q;
    logic [TMR_W-1:0] tmr_q;

    assign kill_o = busy && sq_valid && (tid_o == sq_tid) && (seq_q > sq_seq);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            tmr_q   <= '0;
            tid_o   <= '0;
            stage_o <= '0;
            seq_q   <= '0;
        end else if (load) begin
            busy    <= 1'b1;
            tmr_q   <= TMR_W'(WAKE_DLY);
            tid_o   <= ld_tid;
            stage_o <= ld_stage;
            seq_q   <= ld_seq;
        end else if (kill_o) begin
            busy  <= 1'b0;
            tmr_q <= '0;
        end else if (busy) begin
            if (tmr_q == TMR_W'(1)) begin
                busy  <= 1'b0;
                tmr_q <= '0;
            end else begin
                tmr_q <= tmr_q - TMR_W'(1);
            end
        end
    end
endmodule

// File: rtl/xlat_slot_mgr.sv
module xlat_slot_mgr
    import xlat_pkg::*;
#(
    parameter int NUM_SLOTS   = 4,
    parameter int NUM_THREADS = 4,
    parameter int NUM_STAGES  = 4,
    parameter int SEQ_W       = 8,
    parameter int VA_W        = 16,
    parameter int PA_W        = 16,
    parameter int FC_W        = 4,
    parameter int WAKE_DLY    = 1,
    localparam int TID_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int STG_W  = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [TID_W-1:0]       req_tid,
    input  logic [STG_W-1:0]       req_stage,
    input  logic [SEQ_W-1:0]       req_seq,
    input  logic [1:0]             req_cmd,
    input  logic                   req_prefetch,
    input  logic [VA_W-1:0]        req_vaddr,
    output logic                   lk_valid,
    output logic [VA_W-1:0]        lk_vaddr,
    output logic [1:0]             lk_perm,
    input  logic                   lk_fault,
    input  logic [FC_W-1:0]        lk_fault_code,
    input  logic [PA_W-1:0]        lk_paddr,
    input  logic                   sq_valid,
    input  logic [TID_W-1:0]       sq_tid,
    input  logic [SEQ_W-1:0]       sq_seq,
    output logic                   rsp_valid,
    output logic [1:0]             rsp_status,
    output logic [SLOT_W-1:0]      rsp_slot,
    output logic [PA_W-1:0]        rsp_paddr,
    output logic                   trap_valid,
    output logic [TID_W-1:0]       trap_tid,
    output logic [FC_W-1:0]        trap_code,
    output logic [NUM_STAGES-1:0]  stall_o,
    output logic [NUM_THREADS-1:0] blocked_o,
    output logic [NUM_SLOTS-1:0]   squash_mask
);
    logic [NUM_SLOTS-1:0] busy, load, kill;
    logic [TID_W-1:0]     s_tid   [NUM_SLOTS];
    logic [STG_W-1:0]     s_stage [NUM_SLOTS];
    logic                 any_free;
    logic [SLOT_W-1:0]    free_idx;
    logic                 legal, thr_blocked, accept, eff_fault;

    xlat_free_pick #(.N(NUM_SLOTS), .IDX_W(SLOT_W)) pick_i (
        .busy(busy), .any_free(any_free), .idx(free_idx)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        xlat_slot_entry #(
            .TID_W(TID_W), .STG_W(STG_W), .SEQ_W(SEQ_W), .WAKE_DLY(WAKE_DLY)
        ) ent_i (
            .clk(clk), .rst(rst), .load(load[i]),
            .ld_tid(req_tid), .ld_stage(req_stage), .ld_seq(req_seq),
            .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
            .busy(busy[i]), .tid_o(s_tid[i]), .stage_o(s_stage[i]),
            .kill_o(kill[i])
        );
        assign load[i] = accept && eff_fault && (free_idx == SLOT_W'(i));
    end

    always_comb begin
        blocked_o = '0;
        stall_o   = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (busy[i]) begin
                blocked_o[s_tid[i]]  = 1'b1;
                stall_o[s_stage[i]]  = 1'b1;
            end
        end
    end

    assign legal       = cmd_legal(req_cmd);
    assign thr_blocked = blocked_o[req_tid];
    assign accept      = req_valid && legal && !thr_blocked && any_free;
    assign eff_fault   = lk_fault && !(cmd_is_data(req_cmd) && req_prefetch);

    assign lk_valid = accept;
    assign lk_vaddr = req_vaddr;
    assign lk_perm  = cmd_perm(req_cmd);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_status  <= ST_DONE;
            rsp_slot    <= '0;
            rsp_paddr   <= '0;
            trap_valid  <= 1'b0;
            trap_tid    <= '0;
            trap_code   <= '0;
            squash_mask <= '0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_slot    <= accept ? free_idx : '0;
            rsp_paddr   <= (accept && !eff_fault) ? lk_paddr : '0;
            trap_valid  <= accept && eff_fault;
            trap_tid    <= req_tid;
            trap_code   <= lk_fault_code;
            squash_mask <= kill;
            if (!legal)                          rsp_status <= ST_ILLEGAL;
            else if (thr_blocked || !any_free)   rsp_status <= ST_REJECT;
            else if (eff_fault)                  rsp_status <= ST_FAULT;
            else                                 rsp_status <= ST_DONE;
        end
    end
endmodule

// File: rtl/xlat_slot_mgr_chk.sv
module xlat_slot_mgr_chk #(
    parameter int NUM_SLOTS   = 4,
    parameter int NUM_THREADS = 4,
    parameter int NUM_STAGES  = 4,
    parameter int TID_W       = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   req_valid,
    input logic [TID_W-1:0]       req_tid,
    input logic [1:0]             req_cmd,
    input logic                   lk_valid,
    input logic [1:0]             lk_perm,
    input logic                   sq_valid,
    input logic                   rsp_valid,
    input logic [1:0]             rsp_status,
    input logic                   trap_valid,
    input logic [TID_W-1:0]       trap_tid,
    input logic [NUM_THREADS-1:0] blocked_o,
    input logic [NUM_SLOTS-1:0]   squash_mask
);
    p_fetch_exec_r3: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && req_cmd == 2'd0) |-> lk_perm == 2'd0);

    p_illegal_nolookup_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_cmd == 2'd3) |-> !lk_valid);

    p_blocked_reject_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_cmd != 2'd3 && blocked_o[req_tid]) |=> (rsp_valid && rsp_status == 2'd2));

    p_trap_is_fault_r5: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> (rsp_valid && rsp_status == 2'd1));

    p_trap_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> blocked_o[trap_tid]);

    p_done_no_trap_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 2'd0) |-> !trap_valid);

    p_squash_cause_r10: assert property (@(posedge clk) disable iff (rst)
        !sq_valid |=> squash_mask == '0);
endmodule

bind xlat_slot_mgr xlat_slot_mgr_chk #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_THREADS(NUM_THREADS),
    .NUM_STAGES(NUM_STAGES), .TID_W(TID_W)
) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_tid(req_tid),
    .req_cmd(req_cmd), .lk_valid(lk_valid), .lk_perm(lk_perm),
    .sq_valid(sq_valid), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .trap_valid(trap_valid), .trap_tid(trap_tid), .blocked_o(blocked_o),
    .squash_mask(squash_mask)
);

// File: tb/xlat_slot_mgr_tb.sv
module xlat_slot_mgr_tb_top;
    localparam int NS = 2, NT = 4, NG = 4, SW = 8, VW = 16, PW = 16, FW = 4, WD = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          req_valid = 0, req_prefetch = 0;
    logic [1:0]    req_tid = 0, req_stage = 0, req_cmd = 0;
    logic [SW-1:0] req_seq = 0;
    logic [VW-1:0] req_vaddr = 0;
    logic          lk_valid, lk_fault;
    logic [VW-1:0] lk_vaddr;
    logic [1:0]    lk_perm;
    logic [FW-1:0] lk_fault_code;
    logic [PW-1:0] lk_paddr;
    logic          sq_valid = 0;
    logic [1:0]    sq_tid = 0;
    logic [SW-1:0] sq_seq = 0;
    logic          rsp_valid, trap_valid;
    logic [1:0]    rsp_status, trap_tid;
    logic [0:0]    rsp_slot;
    logic [PW-1:0] rsp_paddr;
    logic [FW-1:0] trap_code;
    logic [NG-1:0] stall_o;
    logic [NT-1:0] blocked_o;
    logic [NS-1:0] squash_mask;

    xlat_slot_mgr #(
        .NUM_SLOTS(NS), .NUM_THREADS(NT), .NUM_STAGES(NG), .SEQ_W(SW),
        .VA_W(VW), .PA_W(PW), .FC_W(FW), .WAKE_DLY(WD)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_tid(req_tid),
        .req_stage(req_stage), .req_seq(req_seq), .req_cmd(req_cmd),
        .req_prefetch(req_prefetch), .req_vaddr(req_vaddr),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_perm(lk_perm),
        .lk_fault(lk_fault), .lk_fault_code(lk_fault_code), .lk_paddr(lk_paddr),
        .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_slot(rsp_slot),
        .rsp_paddr(rsp_paddr), .trap_valid(trap_valid), .trap_tid(trap_tid),
        .trap_code(trap_code), .stall_o(stall_o), .blocked_o(blocked_o),
        .squash_mask(squash_mask)
    );

    // Lookup port model: page 0xF faults; mapping folds the permission in.
    function automatic logic [PW-1:0] mdl_pa(input logic [VW-1:0] va, input logic [1:0] p);
        return {2'b10, p, va[11:0]};
    endfunction
    function automatic logic [FW-1:0] mdl_fc(input logic [VW-1:0] va, input logic [1:0] p);
        return va[3:0] ^ {2'b00, p};
    endfunction
    always_comb begin
        lk_fault      = (lk_vaddr[15:12] == 4'hF);
        lk_fault_code = mdl_fc(lk_vaddr, lk_perm);
        lk_paddr      = mdl_pa(lk_vaddr, lk_perm);
    end

    int nchk = 0, nfail = 0;
    bit finished = 0;
    logic lk_seen;

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] cmd, input logic pf, input logic [1:0] tid,
                         input logic [1:0] stg, input logic [SW-1:0] seq, input logic [VW-1:0] va);
        @(negedge clk);
        req_valid = 1; req_cmd = cmd; req_prefetch = pf; req_tid = tid;
        req_stage = stg; req_seq = seq; req_vaddr = va;
        #1 lk_seen = lk_valid;
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic squash(input logic [1:0] tid, input logic [SW-1:0] seq);
        @(negedge clk);
        sq_valid = 1; sq_tid = tid; sq_seq = seq;
        @(posedge clk); #1;
        sq_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // {cmd, prefetch, tid, stage, vaddr, expected status}
    localparam int NV = 9;
    localparam logic [24:0] VECS [NV] = '{
        {2'd0, 1'b0, 2'd0, 2'd1, 16'h1234, 2'd0},
        {2'd1, 1'b0, 2'd1, 2'd2, 16'h2abc, 2'd0},
        {2'd2, 1'b0, 2'd2, 2'd3, 16'h0fff, 2'd0},
        {2'd3, 1'b0, 2'd3, 2'd0, 16'h4444, 2'd3},
        {2'd0, 1'b0, 2'd0, 2'd1, 16'hF01A, 2'd1},
        {2'd1, 1'b1, 2'd1, 2'd2, 16'hF025, 2'd0},
        {2'd2, 1'b1, 2'd3, 2'd0, 16'hF036, 2'd0},
        {2'd0, 1'b1, 2'd2, 2'd3, 16'hF047, 2'd1},
        {2'd1, 1'b0, 2'd3, 2'd2, 16'hF058, 2'd1}
    };

    initial begin
        #(8 * 20000);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 rsp_valid", rsp_valid, 0);
        check("R1 trap_valid", trap_valid, 0);
        check("R1 blocked", blocked_o, 0);
        check("R1 stall", stall_o, 0);
        check("R1 squash_mask", squash_mask, 0);
        @(negedge clk) rst = 0;
        idle(2);

        for (int v = 0; v < NV; v++) begin
            logic [1:0] cmd, tid, stg, est, perm;
            logic pf;
            logic [VW-1:0] va;
            {cmd, pf, tid, stg, va, est} = VECS[v];
            perm = (cmd == 2'd1) ? 2'd1 : (cmd == 2'd2) ? 2'd2 : 2'd0;
            apply(cmd, pf, tid, stg, 8'(v), va);
            check("R3 R4 R5 R6 status", rsp_status, est);
            check("R2 slot", rsp_slot, 0);
            if (est == 2'd3) begin
                check("R3 no lookup", lk_seen, 0);
            end else if (est == 2'd0) begin
                check("R3 R4 R6 paddr", rsp_paddr, mdl_pa(va, perm));
                check("R6 no trap", trap_valid, 0);
                check("R6 no block", blocked_o, 0);
            end else begin
                check("R5 trap", trap_valid, 1);
                check("R5 trap tid", trap_tid, tid);
                check("R5 trap code", trap_code, mdl_fc(va, perm));
                check("R5 block", blocked_o[tid], 1);
                check("R5 stall", stall_o[stg], 1);
            end
            idle(5);
        end

        // R9 wake-up timing
        apply(2'd1, 0, 2'd0, 2'd1, 8'd1, 16'hF100);
        check("R9 blocked at fault", blocked_o, 4'b0001);
        idle(2);
        check("R9 still blocked", blocked_o, 4'b0001);
        check("R9 still stalled", stall_o, 4'b0010);
        idle(1);
        check("R9 unblocked", blocked_o, 0);
        check("R9 stall released", stall_o, 0);
        idle(3);

        // R7 blocked thread rejected, other thread served on next slot
        apply(2'd0, 0, 2'd0, 2'd1, 8'd2, 16'hF200);
        apply(2'd1, 0, 2'd0, 2'd1, 8'd3, 16'h1000);
        check("R7 reject blocked", rsp_status, 2);
        check("R7 no lookup", lk_seen, 0);
        apply(2'd1, 0, 2'd1, 2'd2, 8'd4, 16'h1000);
        check("R7 other thread done", rsp_status, 0);
        check("R2 lowest free slot", rsp_slot, 1);
        idle(5);

        // R8 all slots held
        apply(2'd1, 0, 2'd0, 2'd1, 8'd5, 16'hF300);
        apply(2'd2, 0, 2'd1, 2'd2, 8'd6, 16'hF301);
        check("R2 second slot", rsp_slot, 1);
        apply(2'd1, 0, 2'd2, 2'd3, 8'd7, 16'h1000);
        check("R8 full reject", rsp_status, 2);
        idle(5);

        // R10 selective squash with wake-up cancel
        apply(2'd1, 0, 2'd0, 2'd1, 8'd10, 16'hF400);
        apply(2'd1, 0, 2'd1, 2'd2, 8'd20, 16'hF401);
        squash(2'd0, 8'd9);
        check("R10 squash mask", squash_mask, 2'b01);
        check("R10 block cleared", blocked_o, 4'b0010);
        check("R10 stall released", stall_o, 4'b0100);
        apply(2'd1, 0, 2'd0, 2'd1, 8'd11, 16'h1000);
        check("R10 slot freed", rsp_status, 0);
        check("R10 slot reused", rsp_slot, 0);
        idle(5);

        // R11 equal sequence and other thread untouched
        apply(2'd1, 0, 2'd0, 2'd1, 8'd10, 16'hF500);
        squash(2'd0, 8'd10);
        check("R11 equal seq mask", squash_mask, 0);
        check("R11 equal seq blocked", blocked_o, 4'b0001);
        squash(2'd1, 8'd0);
        check("R11 other thread mask", squash_mask, 0);
        check("R11 other thread blocked", blocked_o, 4'b0001);
        check("R11 stall kept", stall_o, 4'b0010);
        idle(5);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule